// File: doc/BRIEF.md
# Motion Sensor Serial Command Sequencer

This block is the host side of a three-wire synchronous serial link to an optical motion sensor. It drives an active-low chip select and a serial clock, and shares one bidirectional data line with the sensor. A request carries a command kind, a register address, a write byte and a burst length. The sequencer then runs a single-register write, a single-register read or a motion burst read. Every byte that comes back from the sensor is presented for one cycle on a response strobe with its data.

The sensor needs settling time between commands, and the amount depends on which kinds of command meet. The sequencer remembers the kind of the last finished command. It holds off the next one until the matching gap, counted in system clock cycles, has passed. It also leaves a turnaround pause between a read address and the first returned bit. A motion burst sends only the dedicated burst address. It then clocks back a caller-chosen number of bytes, from two to eight, with no pause between bytes. The sensor sends them in its fixed order: motion status, X low, Y low, XY high bits, surface quality, shutter high, shutter low, peak pixel.

Top module: `sensor_serial_seq`

## Requirements
- R1: After reset, chip select and serial clock are high, and busy, error and response strobes are low.
- R2: The serial clock idles high whenever chip select is high. The master changes data only on falling clock edges. The first byte of each frame is the command byte, sent most significant bit first: bit 7 is 1 for a write and 0 for a read or burst, and bits 6..0 are the register address.
- R3: A write frame is exactly 16 clock pulses: the command byte followed by the write byte, most significant bit first. The data line stays driven by the master throughout.
- R4: A read frame is the command byte followed by 8 pulses. The master releases the data line after the command byte, samples on rising edges, and emits the byte once on rsp_valid/rsp_data.
- R5: A burst (kind 2) sends the burst register address BURST_ADDR with bit 7 clear. It then clocks exactly req_blen bytes, with every data rising edge 2*HALF cycles after the previous one (no pause between bytes). Each byte is emitted in arrival order.
- R6: A burst with req_blen below 2 or above 8, and any request of kind 3, is refused. req_err pulses for one cycle and no frame starts.
- R7: After a write, chip select stays high at least T_WW cycles before a write and at least T_WR cycles before a read or burst.
- R8: After a read, chip select stays high at least T_RW cycles before a write and at least T_RR cycles before a read or burst.
- R9: After a burst, chip select stays high at least T_BX cycles before any command, including another burst.
- R10: busy is high while a frame is in progress and until the gap for the presented req_kind has elapsed. A request held while busy starts exactly one cycle after the gap ends. A request pulsed while busy is ignored.
- R11: In reads and bursts, the first data falling edge comes at least T_RAD cycles after the last command-byte rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken in a cycle where busy is low |
| req_kind | input | 2 | 0 write, 1 read, 2 burst, 3 reserved |
| req_addr | input | 7 | Register address (ignored for bursts) |
| req_wdata | input | 8 | Byte to write |
| req_blen | input | LW | Burst byte count |
| busy | output | 1 | Sequencer cannot take a request of the presented kind |
| req_err | output | 1 | One-cycle pulse on a refused request |
| rsp_valid | output | 1 | One-cycle strobe for a returned byte |
| rsp_data | output | 8 | Returned byte |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle high |
| sdio_o | output | 1 | Data driven by the master |
| sdio_oe | output | 1 | Master drives the data line when high |
| sdio_i | input | 1 | Data line as seen by the master |

## Verification
The bound checker watches, on every cycle, the local line rules. The clock stays high outside a frame and data holds still while the clock is high. busy stays up during a frame, a refusal never coincides with a frame, and response strobes occur only while the data line is released. The inter-command gaps are different: their correctness depends on the pair of command kinds. The exact release point of busy, the turnaround pause, the back-to-back burst spacing, the byte counts and the returned data are therefore shown only by the bench's scenarios. There, a sensor model answers each frame and a behavioural monitor measures every interval against the kind that came before.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_BURST = 2'd2,
    K_RSVD  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    P_NONE,
    P_WRITE,
    P_READ,
    P_BURST
  } last_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEAD,
    S_ADDR,
    S_TURN,
    S_RDATA,
    S_WDATA
  } seq_state_e;

  localparam int BURST_MAX = 8;
  localparam int BURST_MIN = 2;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sseq_gap_timer.sv
module sseq_gap_timer
  import sseq_pkg::*;
#(
  parameter int T_WW = 5,
  parameter int T_WR = 7,
  parameter int T_RR = 4,
  parameter int T_RW = 9,
  parameter int T_BX = 12
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      done,
  input  last_cmd_e done_kind,
  output logic      ok_wr,
  output logic      ok_rd
);
  localparam int GMAX = imax(imax(imax(T_WW, T_WR), imax(T_RR, T_RW)), T_BX);
  localparam int GW   = imax(1, $clog2(GMAX + 1));
  localparam logic [GW-1:0] GSAT = GW'(GMAX);

  last_cmd_e     last;
  logic [GW-1:0] since;
  logic [GW-1:0] need_w, need_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      last  <= P_NONE;
      since <= '0;
    end else if (done) begin
      last  <= done_kind;
      since <= '0;
    end else if (since != GSAT) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    case (last)
      P_WRITE: begin need_w = GW'(T_WW); need_r = GW'(T_WR); end
      P_READ:  begin need_w = GW'(T_RW); need_r = GW'(T_RR); end
      P_BURST: begin need_w = GW'(T_BX); need_r = GW'(T_BX); end
      default: begin need_w = '0;        need_r = '0;        end
    endcase
  end

  assign ok_wr = (last == P_NONE) || (since >= need_w);
  assign ok_rd = (last == P_NONE) || (since >= need_r);
endmodule

// File: rtl/sseq_byte_engine.sv
module sseq_byte_engine #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       sdi,
  output logic       sclk,
  output logic       sdo,
  output logic       byte_end,
  output logic       rx_valid,
  output logic [7:0] rx_byte
);
  localparam int CW = (2 * HALF > 2) ? $clog2(2 * HALF) : 1;
  localparam logic [CW-1:0] C_RISE = CW'(HALF - 1);
  localparam logic [CW-1:0] C_LAST = CW'(2 * HALF - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    tsh, rsh;

  assign byte_end = active && (bitn == 3'd0) && (cnt == C_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      bitn     <= '0;
      tsh      <= '0;
      rsh      <= '0;
      sclk     <= 1'b1;
      sdo      <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        bitn   <= 3'd7;
        sclk   <= 1'b0;
        sdo    <= tx_byte[7];
        tsh    <= {tx_byte[6:0], 1'b0};
      end else if (active) begin
        if (cnt == C_RISE) begin
          sclk <= 1'b1;
          rsh  <= {rsh[6:0], sdi};
          cnt  <= cnt + 1'b1;
          if (bitn == 3'd0) begin
            rx_valid <= 1'b1;
            rx_byte  <= {rsh[6:0], sdi};
          end
        end else if (cnt == C_LAST) begin
          if (bitn == 3'd0) begin
            active <= 1'b0;
          end else begin
            sclk <= 1'b0;
            sdo  <= tsh[7];
            tsh  <= {tsh[6:0], 1'b0};
            bitn <= bitn - 1'b1;
            cnt  <= '0;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sensor_serial_seq.sv
module sensor_serial_seq
  import sseq_pkg::*;
#(
  parameter int          HALF       = 2,
  parameter int          T_WW       = 5,
  parameter int          T_WR       = 7,
  parameter int          T_RR       = 4,
  parameter int          T_RW       = 9,
  parameter int          T_BX       = 12,
  parameter int          T_RAD      = 6,
  parameter int          LW         = 4,
  parameter logic [6:0]  BURST_ADDR = 7'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [6:0]    req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [LW-1:0] req_blen,
  output logic          busy,
  output logic          req_err,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          cs_n,
  output logic          sclk,
  output logic          sdio_o,
  output logic          sdio_oe,
  input  logic          sdio_i
);
  localparam int TW = (T_RAD > 1) ? $clog2(T_RAD) : 1;
  localparam logic [TW-1:0] TLAST = TW'(T_RAD - 1);

  seq_state_e    st;
  cmd_kind_e     k, kind_q;
  logic [6:0]    addr_q;
  logic [7:0]    wdata_q;
  logic [LW-1:0] left;
  logic [TW-1:0] tcnt;
  logic          ok_wr, ok_rd, gap_ok, bad, take, refuse;
  logic          eng_start, eng_end, eng_rx_valid;
  logic [7:0]    eng_tx, eng_rx_byte;
  logic          done;
  last_cmd_e     done_kind;

  assign k      = cmd_kind_e'(req_kind);
  assign gap_ok = (k == K_WRITE) ? ok_wr : ok_rd;
  assign busy   = !((st == S_IDLE) && gap_ok);
  assign bad    = (k == K_RSVD) ||
                  ((k == K_BURST) && ((req_blen < LW'(BURST_MIN)) || (req_blen > LW'(BURST_MAX))));
  assign take   = req_valid && !busy && !bad;
  assign refuse = req_valid && !busy && bad;

  always_comb begin
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    case (st)
      S_LEAD: begin
        eng_start = 1'b1;
        eng_tx    = {kind_q == K_WRITE, addr_q};
      end
      S_ADDR: if (eng_end && kind_q == K_WRITE) begin
        eng_start = 1'b1;
        eng_tx    = wdata_q;
      end
      S_TURN:  eng_start = (tcnt == TLAST);
      S_RDATA: eng_start = eng_end && (left > LW'(1));
      default: ;
    endcase
  end

  assign done = eng_end && ((st == S_WDATA) || ((st == S_RDATA) && (left <= LW'(1))));

  always_comb begin
    case (kind_q)
      K_WRITE: done_kind = P_WRITE;
      K_BURST: done_kind = P_BURST;
      default: done_kind = P_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      kind_q  <= K_WRITE;
      addr_q  <= '0;
      wdata_q <= '0;
      left    <= '0;
      tcnt    <= '0;
      cs_n    <= 1'b1;
      sdio_oe <= 1'b1;
      req_err <= 1'b0;
    end else begin
      req_err <= refuse;
      case (st)
        S_IDLE: if (take) begin
          cs_n    <= 1'b0;
          kind_q  <= k;
          addr_q  <= (k == K_BURST) ? BURST_ADDR : req_addr;
          wdata_q <= req_wdata;
          left    <= (k == K_BURST) ? req_blen : LW'(1);
          st      <= S_LEAD;
        end
        S_LEAD: st <= S_ADDR;
        S_ADDR: if (eng_end) begin
          if (kind_q == K_WRITE) begin
            st <= S_WDATA;
          end else begin
            st      <= S_TURN;
            sdio_oe <= 1'b0;
            tcnt    <= '0;
          end
        end
        S_TURN: begin
          if (tcnt == TLAST) st <= S_RDATA;
          else               tcnt <= tcnt + 1'b1;
        end
        S_RDATA: if (eng_end && left > LW'(1)) left <= left - 1'b1;
        default: ;
      endcase
      if (done) begin
        st      <= S_IDLE;
        cs_n    <= 1'b1;
        sdio_oe <= 1'b1;
      end
    end
  end

  sseq_gap_timer #(
    .T_WW(T_WW), .T_WR(T_WR), .T_RR(T_RR), .T_RW(T_RW), .T_BX(T_BX)
  ) u_gap (
    .clk(clk), .rst(rst), .done(done), .done_kind(done_kind),
    .ok_wr(ok_wr), .ok_rd(ok_rd)
  );

  sseq_byte_engine #(.HALF(HALF)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx), .sdi(sdio_i),
    .sclk(sclk), .sdo(sdio_o), .byte_end(eng_end),
    .rx_valid(eng_rx_valid), .rx_byte(eng_rx_byte)
  );

  assign rsp_valid = eng_rx_valid && (st == S_RDATA);
  assign rsp_data  = eng_rx_byte;
endmodule

// File: rtl/sseq_checker.sv
module sseq_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic sdio_o,
  input logic sdio_oe,
  input logic busy,
  input logic req_err,
  input logic rsp_valid
);
  p_clk_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  p_data_moves_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sclk && $past(sclk)) |-> $stable(sdio_o));

  p_busy_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  p_refuse_no_frame_r6: assert property (@(posedge clk) disable iff (rst)
    req_err |-> cs_n);

  p_rsp_line_released_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!cs_n && !sdio_oe));

  p_driven_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sdio_oe);
endmodule

bind sensor_serial_seq sseq_checker u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_o(sdio_o),
  .sdio_oe(sdio_oe), .busy(busy), .req_err(req_err), .rsp_valid(rsp_valid)
);

// File: tb/sensor_serial_seq_bench.sv
module sensor_serial_seq_bench;
  localparam int HALF = 2, T_WW = 5, T_WR = 7, T_RR = 4, T_RW = 9, T_BX = 12, T_RAD = 6, LW = 4;
  localparam logic [6:0] BADDR = 7'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [LW-1:0] req_blen = '0;
  logic busy, req_err, rsp_valid, cs_n, sclk, sdio_o, sdio_oe;
  logic [7:0] rsp_data;
  logic sdio_i = 1'b0;

  always #10 clk = ~clk;

  sensor_serial_seq #(
    .HALF(HALF), .T_WW(T_WW), .T_WR(T_WR), .T_RR(T_RR), .T_RW(T_RW),
    .T_BX(T_BX), .T_RAD(T_RAD), .LW(LW), .BURST_ADDR(BADDR)
  ) u_sensor_serial_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_blen(req_blen),
    .busy(busy), .req_err(req_err), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cs_n(cs_n), .sclk(sclk), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  typedef struct {
    int kind; int addr; int wdata; int blen; bit pending;
  } req_t;

  req_t exp_q[$];
  req_t cur;
  logic [7:0] rsp_exp[$];
  int checks = 0, errors = 0;
  int prev_kind = 0, hi_len = 0, nbits = 0, cyc = 0, last_rise = 0;
  int frames = 0, accepted = 0;
  bit finished = 0, prev_cs = 1, prev_sclk = 1;
  logic [7:0] a_sh, w_sh;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int need_of(input int prev, input int kind);
    if (prev == 1) return (kind == 0) ? T_WW : T_WR;
    if (prev == 2) return (kind == 0) ? T_RW : T_RR;
    if (prev == 3) return T_BX;
    return 0;
  endfunction

  function automatic logic [7:0] slave_byte(input req_t r, input int idx);
    if (r.kind == 2) return 8'(8'h3C + idx * 8'h29);
    return 8'((r.addr * 7) ^ 8'h96);
  endfunction

  task automatic monitor();
    forever begin
      @(negedge clk);
      if (!rst) begin
        cyc++;
        chk(!cs_n || sclk, "R2 clock idles high", int'(sclk), 1);
        if (prev_cs && !cs_n) begin
          frames++;
          if (exp_q.size() == 0) begin
            chk(0, "R6/R10 unexpected frame", frames, accepted);
            cur = '{kind: 1, addr: 0, wdata: 0, blen: 1, pending: 0};
          end else begin
            int nd;
            cur = exp_q.pop_front();
            nd = need_of(prev_kind, cur.kind);
            if (prev_kind == 1) chk(hi_len >= nd, "R7 gap after write", hi_len, nd);
            if (prev_kind == 2) chk(hi_len >= nd, "R8 gap after read", hi_len, nd);
            if (prev_kind == 3) chk(hi_len >= nd, "R9 gap after burst", hi_len, nd);
            if (prev_kind != 0 && cur.pending)
              chk(hi_len == nd + 1, "R10 busy release point", hi_len, nd + 1);
          end
          nbits = 0; a_sh = '0; w_sh = '0;
        end
        if (!prev_cs && cs_n) begin
          int eb;
          logic [7:0] ea;
          eb = (cur.kind == 0) ? 16 : 8 + 8 * ((cur.kind == 2) ? cur.blen : 1);
          ea = (cur.kind == 0) ? {1'b1, 7'(cur.addr)} :
               (cur.kind == 2) ? {1'b0, BADDR} : {1'b0, 7'(cur.addr)};
          chk(nbits == eb, (cur.kind == 0) ? "R3 write pulses" : (cur.kind == 2) ? "R5 burst pulses" : "R4 read pulses", nbits, eb);
          chk(a_sh == ea, "R2 command byte", int'(a_sh), int'(ea));
          if (cur.kind == 0) chk(w_sh == 8'(cur.wdata), "R3 write byte", int'(w_sh), cur.wdata);
          prev_kind = cur.kind + 1;
        end
        if (!cs_n && !prev_sclk && sclk) begin
          if (nbits < 8) begin
            a_sh = {a_sh[6:0], sdio_o};
            chk(sdio_oe == 1'b1, "R2 command byte driven", int'(sdio_oe), 1);
          end else if (cur.kind == 0) begin
            w_sh = {w_sh[6:0], sdio_o};
            chk(sdio_oe == 1'b1, "R3 write byte driven", int'(sdio_oe), 1);
          end else begin
            chk(sdio_oe == 1'b0, "R4 line released", int'(sdio_oe), 0);
            if (nbits > 8) chk(cyc - last_rise == 2 * HALF, "R5 back to back spacing", cyc - last_rise, 2 * HALF);
          end
          last_rise = cyc;
          nbits++;
        end
        if (!cs_n && prev_sclk && !sclk && cur.kind != 0 && nbits >= 8) begin
          logic [7:0] b;
          if (nbits == 8) chk(cyc - last_rise >= T_RAD, "R11 turnaround", cyc - last_rise, T_RAD);
          b = slave_byte(cur, (nbits - 8) / 8);
          if (nbits % 8 == 0) rsp_exp.push_back(b);
          sdio_i = b[7 - (nbits % 8)];
        end
        if (rsp_valid) begin
          if (rsp_exp.size() == 0) chk(0, "R4 unexpected response", int'(rsp_data), -1);
          else begin
            logic [7:0] e;
            e = rsp_exp.pop_front();
            chk(rsp_data == e, (cur.kind == 2) ? "R5 burst byte" : "R4 read byte", int'(rsp_data), int'(e));
          end
        end
        if (cs_n) hi_len++;
        else      hi_len = 0;
        prev_cs = cs_n;
        prev_sclk = sclk;
      end
    end
  endtask

  task automatic issue(input int kind, input int addr, input int wdata, input int blen);
    bit pend;
    @(negedge clk);
    req_kind = 2'(kind); req_addr = 7'(addr); req_wdata = 8'(wdata); req_blen = LW'(blen);
    req_valid = 1'b1;
    #1;
    pend = busy;
    while (busy) @(negedge clk);
    exp_q.push_back('{kind: kind, addr: addr, wdata: wdata, blen: blen, pending: pend});
    accepted++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refuse(input int kind, input int blen);
    @(negedge clk);
    req_kind = 2'(kind); req_blen = LW'(blen); req_valid = 1'b1;
    #1;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, "R6 refusal strobe", int'(req_err), 1);
    chk(cs_n == 1'b1, "R6 no frame on refusal", int'(cs_n), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    fork
      monitor();
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          errors++;
          $display("FAIL watchdog R10: got 0 expected 1 (run did not complete)");
          summary();
          $finish;
        end
      end
    join_none

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b1, "R1 sclk", int'(sclk), 1);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(req_err == 1'b0, "R1 req_err", int'(req_err), 0);

    issue(0, 7'h05, 8'hC3, 0);
    issue(0, 7'h2A, 8'h5E, 0);
    issue(1, 7'h11, 0, 0);
    issue(1, 7'h22, 0, 0);
    issue(0, 7'h33, 8'hA5, 0);
    issue(2, 0, 0, 8);
    issue(2, 0, 0, 2);
    issue(1, 7'h7F, 0, 0);
    issue(0, 7'h01, 8'h80, 0);

    repeat (200) @(negedge clk);
    refuse(2, 1);
    refuse(2, 9);
    refuse(3, 4);
    refuse(2, 0);

    issue(2, 0, 0, 5);
    repeat (20) @(negedge clk);
    req_kind = 2'd1; req_addr = 7'h44; req_valid = 1'b1;
    #1;
    chk(busy == 1'b1, "R10 busy during frame", int'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    issue(2, 0, 0, 3);
    issue(1, 7'h0C, 0, 0);

    repeat (300) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all requests run", exp_q.size(), 0);
    chk(rsp_exp.size() == 0, "R4 all bytes returned", rsp_exp.size(), 0);
    chk(frames == accepted, "R10 ignored request", frames, accepted);
    finished = 1;
    summary();
    $finish;
  end
endmodule